// File: doc/BRIEF.md
# LFSR Reload Clock Divider

This block divides a clock by programmable integers without binary counters. Each divider stage is a shift register with XNOR feedback that steps through a fixed chain of states, which ends in one terminal state. When the register sits in the terminal state, it loads a programmable reload value on the next edge, emits a one-cycle tick and toggles its divided output. Software programs a divisor N by writing the chain state that lies N-1 steps before the terminal state. The chain is not written as a count.

There are two such stages. The reference stage is 6 bits wide and covers divisors 1 to 64. The feedback stage is 8 bits wide and is used for divisors 2 to 160. A separate post-divide path has two cascaded 3-bit stages, each dividing by 1 to 8. Each stage takes its divisor as a code equal to 8 minus the divisor, and the second stage counts the ticks of the first. The analog oscillator and phase comparison of a synthesizer are not part of the block. Every stage runs on the single input clock and produces tick pulses and toggled square outputs.

Top module: `lfsr_synth_divider`

## Requirements
- R1: While reset is asserted and at its release, `ref_clk`, `fb_clk` and `post_clk` are 0, and `ref_tick`, `fb_tick` and `post_tick` are 1. Every stage starts in its terminal state, so the first edge after release reloads all of them.
- R2: The reference stage is a 6-bit register whose terminal state is 0x3F. From state 0x00 it steps to 0x3F. From any other non-terminal state s it steps to {s[4:0], ~(s[5]^s[4])}. A reload value v gives one `ref_tick` every N cycles, where N-1 is the number of steps from v to 0x3F. Examples: 0x3F gives 1, 0x00 gives 2, 0x20 gives 3 and 0x01 gives 64.
- R3: The feedback stage is an 8-bit register whose terminal state is 0xFF. From state 0x00 it steps to 0xFF. From any other non-terminal state s it steps to {s[6:0], ~(s[7]^s[3]^s[2]^s[1])}. Examples: 0x00 gives 2, 0x80 gives 3, 0xC0 gives 4 and 0x69 gives 160.
- R4: Each of `ref_clk` and `fb_clk` inverts on the edge that ends a cycle in which its tick is high, and holds on every other edge. Each half-period therefore lasts N cycles.
- R5: A reload value is sampled only on the edge that leaves the terminal state. A write during a period does not change that period. A write in the same cycle as the tick takes effect for the period that starts at that edge.
- R6: `post_code[2:0]` is 8-pd1 and `post_code[5:3]` is 8-pd2, so code 0 means divide by 8 and code 7 means divide by 1. `post_tick` occurs every pd1*pd2 cycles, and `post_clk` inverts on the edge after each `post_tick`.
- R7: Each post stage reads its code only on the edge where it wraps. A code change during a post period therefore changes only the wraps that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_reload | input | 6 | Reload state for the reference stage |
| fb_reload | input | 8 | Reload state for the feedback stage |
| post_code | input | 6 | Post-divide codes: [2:0]=8-pd1, [5:3]=8-pd2 |
| ref_tick | output | 1 | High in the cycle the reference stage is terminal |
| ref_clk | output | 1 | Reference divided square output |
| fb_tick | output | 1 | High in the cycle the feedback stage is terminal |
| fb_clk | output | 1 | Feedback divided square output |
| post_tick | output | 1 | High when both post stages wrap together |
| post_clk | output | 1 | Post-divided square output |

## Verification
Two events can fall in the same cycle: a stage's terminal reload and a write of a new reload value or post code. The bench provokes this on purpose. It waits for a falling edge at which the tick is high, writes the new value at that same edge, and then requires the very next interval to equal the new divisor. A reference model in the bench runs cycle by cycle and tracks the remaining cycles of each stage with integers. It compares every output on every cycle, so writes made in the middle of a period are also judged. The model uses divisor tables that the bench builds itself: it searches for the feedback taps that reproduce known state sequences.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
   // Default geometry of the divider stages.
   localparam int LSD_REF_W   = 6;
   localparam int LSD_FB_W    = 8;
   localparam int LSD_POST_CW = 3;
   localparam int LSD_POST_N  = 2;

   // XNOR feedback tap masks (bit i set means state bit i feeds back).
   localparam logic [LSD_REF_W-1:0] LSD_REF_TAPS = 6'h30;
   localparam logic [LSD_FB_W-1:0]  LSD_FB_TAPS  = 8'h8E;
endpackage

// File: rtl/lsd_lfsr_div.sv
module lsd_lfsr_div #(
   parameter int            W    = 6,
   parameter logic [W-1:0]  TAPS = 6'h30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  reload,
   output logic          tick,
   output logic          div_out
);
   // Terminal state sits outside the XNOR cycle (all-ones lockup state);
   // the chain leaves the cycle at all-zeros and enters the terminal.
   localparam logic [W-1:0] TERM = {W{1'b1}};
   localparam logic [W-1:0] LAST = {W{1'b0}};

   if (W < 2) begin : g_bad_width
      $error("lsd_lfsr_div: W must be at least 2");
   end
   if (TAPS[W-1] != 1'b1) begin : g_bad_taps
      $error("lsd_lfsr_div: top bit of TAPS must be set");
   end

   logic [W-1:0] st;
   logic [W-1:0] st_nx;
   logic         fb_bit;
   logic         at_term;

   assign fb_bit  = ~^(st & TAPS);
   assign at_term = (st == TERM);

   always_comb begin
      if (at_term)           st_nx = reload;
      else if (st == LAST)   st_nx = TERM;
      else                   st_nx = {st[W-2:0], fb_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= TERM;
         div_out <= 1'b0;
      end else begin
         st <= st_nx;
         if (at_term) div_out <= ~div_out;
      end
   end

   assign tick = at_term;
endmodule

// File: rtl/lsd_post_stage.sv
module lsd_post_stage #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [CW-1:0] code,
   output logic          tick
);
   // Counts upward from the code to all-ones: (2**CW - code) enabled steps.
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   if (CW < 1) begin : g_bad_cw
      $error("lsd_post_stage: CW must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == TOP);
   assign tick = en & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= TOP;
      else if (en)     cnt <= wrap ? code : cnt + CW'(1);
   end
endmodule

// File: rtl/lfsr_synth_divider.sv
module lfsr_synth_divider
   import lsd_pkg::*;
#(
   parameter int                  REF_W    = LSD_REF_W,
   parameter logic [REF_W-1:0]    REF_TAPS = LSD_REF_TAPS,
   parameter int                  FB_W     = LSD_FB_W,
   parameter logic [FB_W-1:0]     FB_TAPS  = LSD_FB_TAPS,
   parameter int                  POST_CW  = LSD_POST_CW,
   parameter int                  POST_N   = LSD_POST_N
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [REF_W-1:0]            ref_reload,
   input  logic [FB_W-1:0]             fb_reload,
   input  logic [POST_N*POST_CW-1:0]   post_code,
   output logic                        ref_tick,
   output logic                        ref_clk,
   output logic                        fb_tick,
   output logic                        fb_clk,
   output logic                        post_tick,
   output logic                        post_clk
);
   localparam int POST_CODE_W = POST_N * POST_CW;

   if (POST_N < 1) begin : g_bad_post
      $error("lfsr_synth_divider: POST_N must be at least 1");
   end
   if (POST_CODE_W > 32) begin : g_bad_post_w
      $error("lfsr_synth_divider: post code wider than 32 bits");
   end

   lsd_lfsr_div #(.W(REF_W), .TAPS(REF_TAPS)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (ref_reload),
      .tick    (ref_tick),
      .div_out (ref_clk)
   );

   lsd_lfsr_div #(.W(FB_W), .TAPS(FB_TAPS)) u_fb (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (fb_reload),
      .tick    (fb_tick),
      .div_out (fb_clk)
   );

   // Cascade: each stage advances only on the wrap of the stage before it.
   logic [POST_N:0] en_chain;
   assign en_chain[0] = 1'b1;

   for (genvar i = 0; i < POST_N; i++) begin : g_post
      lsd_post_stage #(.CW(POST_CW)) u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (en_chain[i]),
         .code  (post_code[i*POST_CW +: POST_CW]),
         .tick  (en_chain[i+1])
      );
   end

   assign post_tick = en_chain[POST_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         post_clk <= 1'b0;
      else if (post_tick) post_clk <= ~post_clk;
   end
endmodule

// File: rtl/lsd_chk.sv
module lsd_chk (
   input logic clk,
   input logic rst_n,
   input logic ref_tick,
   input logic ref_clk,
   input logic fb_tick,
   input logic fb_clk,
   input logic post_tick,
   input logic post_clk
);
   // R4: reference output flips after a terminal cycle
   p_ref_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_tick |=> (ref_clk != $past(ref_clk)));

   // R4: reference output holds otherwise
   p_ref_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(ref_clk));

   // R4: feedback output flips after a terminal cycle
   p_fb_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fb_tick |=> (fb_clk != $past(fb_clk)));

   // R4: feedback output holds otherwise
   p_fb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fb_tick |=> $stable(fb_clk));

   // R6: post output flips after a joint wrap
   p_post_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      post_tick |=> (post_clk != $past(post_clk)));

   // R6: post output holds otherwise
   p_post_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !post_tick |=> $stable(post_clk));
endmodule

bind lfsr_synth_divider lsd_chk u_chk (.*);

// File: tb/sim_lfsr_synth_divider.sv
module sim_lfsr_synth_divider;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WD_CYCLES  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] ref_reload = 6'h00;
   logic [7:0] fb_reload  = 8'h00;
   logic [5:0] post_code  = 6'h3F;
   logic       ref_tick, ref_clk, fb_tick, fb_clk, post_tick, post_clk;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_synth_divider u0 (
      .clk(clk), .rst_n(rst_n),
      .ref_reload(ref_reload), .fb_reload(fb_reload), .post_code(post_code),
      .ref_tick(ref_tick), .ref_clk(ref_clk),
      .fb_tick(fb_tick), .fb_clk(fb_clk),
      .post_tick(post_tick), .post_clk(post_clk)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 0;
   bit  cmp_on = 0;
   int  ref_div [64];
   int  fb_div  [256];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // ---------- divisor tables derived from known state sequences ----------
   function automatic int step(input int w, input int m, input int s);
      int ones = (1 << w) - 1;
      if (s == 0) return ones;
      return ((s << 1) & ones) | (($countones(s & m) % 2 == 0) ? 1 : 0);
   endfunction

   function automatic int divisor_of(input int w, input int m, input int v);
      int ones = (1 << w) - 1;
      int s = v;
      int n = 1;
      while (s != ones && n < 400) begin
         s = step(w, m, s);
         n++;
      end
      return n;
   endfunction

   int p6 [12][2] = '{'{8'h0A,8'h15},'{8'h15,8'h2A},'{8'h2A,8'h14},'{8'h14,8'h28},
                      '{8'h28,8'h10},'{8'h10,8'h20},'{8'h20,8'h00},'{8'h01,8'h03},
                      '{8'h03,8'h07},'{8'h0F,8'h1F},'{8'h1F,8'h3E},'{8'h3E,8'h3D}};
   int p8 [13][2] = '{'{8'hF0,8'hE0},'{8'hE0,8'hC0},'{8'hC0,8'h80},'{8'h80,8'h00},
                      '{8'h78,8'hF0},'{8'hBC,8'h78},'{8'h5E,8'hBC},'{8'h2F,8'h5E},
                      '{8'h17,8'h2F},'{8'h0B,8'h17},'{8'h85,8'h0B},'{8'hC2,8'h85},
                      '{8'hE1,8'hC2}};

   function automatic int find6();
      for (int m = 32; m < 64; m++) begin
         bit ok = 1;
         for (int i = 0; i < 12; i++)
            if (step(6, m, p6[i][0]) != p6[i][1]) ok = 0;
         if (ok && divisor_of(6, m, 1) == 64) return m;
      end
      return 0;
   endfunction

   function automatic int find8();
      for (int m = 128; m < 256; m++) begin
         bit ok = 1;
         for (int i = 0; i < 13; i++)
            if (step(8, m, p8[i][0]) != p8[i][1]) ok = 0;
         if (ok) return m;
      end
      return 0;
   endfunction

   // ---------- cycle-by-cycle reference model ----------
   int m_ref_rem, m_fb_rem, m_p1_rem, m_p2_rem;
   bit m_ref_clk, m_fb_clk, m_post_clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ref_rem = 1; m_fb_rem = 1; m_p1_rem = 1; m_p2_rem = 1;
         m_ref_clk = 0; m_fb_clk = 0; m_post_clk = 0;
      end else begin
         if (m_ref_rem == 1) begin
            m_ref_rem = ref_div[ref_reload];
            m_ref_clk = !m_ref_clk;
         end else m_ref_rem--;
         if (m_fb_rem == 1) begin
            m_fb_rem = fb_div[fb_reload];
            m_fb_clk = !m_fb_clk;
         end else m_fb_rem--;
         if (m_p1_rem == 1) begin
            m_p1_rem = 8 - int'(post_code[2:0]);
            if (m_p2_rem == 1) begin
               m_p2_rem = 8 - int'(post_code[5:3]);
               m_post_clk = !m_post_clk;
            end else m_p2_rem--;
         end else m_p1_rem--;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk(ref_tick == (m_ref_rem == 1), "R2 ref_tick", ref_tick, m_ref_rem == 1);
         chk(ref_clk == m_ref_clk, "R4 ref_clk", ref_clk, m_ref_clk);
         chk(fb_tick == (m_fb_rem == 1), "R3 fb_tick", fb_tick, m_fb_rem == 1);
         chk(fb_clk == m_fb_clk, "R4 fb_clk", fb_clk, m_fb_clk);
         chk(post_tick == (m_p1_rem == 1 && m_p2_rem == 1), "R6 post_tick",
             post_tick, m_p1_rem == 1 && m_p2_rem == 1);
         chk(post_clk == m_post_clk, "R6 post_clk", post_clk, m_post_clk);
      end
   end

   // ---------- directed helpers ----------
   function automatic bit tk(input int w);
      case (w)
         0:       return ref_tick;
         1:       return fb_tick;
         default: return post_tick;
      endcase
   endfunction

   task automatic set_val(input int w, input int v);
      case (w)
         0:       ref_reload = v[5:0];
         1:       fb_reload  = v[7:0];
         default: post_code  = v[5:0];
      endcase
   endtask

   task automatic sync_tick(input int w);
      @(negedge clk);
      while (tk(w) != 1'b1) @(negedge clk);
   endtask

   task automatic count_to_tick(input int w, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (tk(w) != 1'b1 && n < 2000);
   endtask

   // Write in the same cycle as a tick, then measure the next interval.
   task automatic meas(input int w, input int v, input int exp, input string req);
      int n;
      sync_tick(w);
      set_val(w, v);
      count_to_tick(w, n);
      chk(n == exp, req, n, exp);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_up();
   end

   initial begin
      int m6, m8, n;
      m6 = find6();
      m8 = find8();
      for (int v = 0; v < 64; v++)  ref_div[v] = divisor_of(6, m6, v);
      for (int v = 0; v < 256; v++) fb_div[v]  = divisor_of(8, m8, v);

      // Derived tables against the stated anchors (R2, R3)
      chk(ref_div[8'h3F] == 1,   "R2 table 0x3F", ref_div[8'h3F], 1);
      chk(ref_div[8'h00] == 2,   "R2 table 0x00", ref_div[8'h00], 2);
      chk(ref_div[8'h20] == 3,   "R2 table 0x20", ref_div[8'h20], 3);
      chk(fb_div[8'h69] == 160,  "R3 table 0x69", fb_div[8'h69], 160);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(ref_clk == 0 && fb_clk == 0 && post_clk == 0, "R1 clocks in reset",
          {ref_clk, fb_clk, post_clk}, 0);
      rst_n = 1'b1;
      chk(ref_tick && fb_tick && post_tick, "R1 ticks at release",
          {ref_tick, fb_tick, post_tick}, 7);
      cmp_on = 1;

      // R2: reference anchors, then every reload value
      meas(0, 8'h3F, 1,  "R2 ref 0x3F");
      meas(0, 8'h00, 2,  "R2 ref 0x00");
      meas(0, 8'h20, 3,  "R2 ref 0x20");
      meas(0, 8'h01, 64, "R2 ref 0x01");
      for (int v = 0; v < 64; v++) meas(0, v, ref_div[v], "R2 ref sweep");

      // R3: feedback anchors, then a spread of values
      meas(1, 8'h00, 2,   "R3 fb 0x00");
      meas(1, 8'h80, 3,   "R3 fb 0x80");
      meas(1, 8'hC0, 4,   "R3 fb 0xC0");
      meas(1, 8'h69, 160, "R3 fb 0x69");
      for (int v = 0; v < 255; v += 7) meas(1, v, fb_div[v], "R3 fb sweep");

      // R5: write in mid-period leaves the running period alone
      sync_tick(0);
      ref_reload = 6'h01;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 10) ref_reload = 6'h00;
      end while (ref_tick != 1'b1 && n < 2000);
      chk(n == 64, "R5 period kept", n, 64);
      count_to_tick(0, n);
      chk(n == 2, "R5 new value next period", n, 2);

      // R6: post-divide codes
      meas(2, 6'h00, 64, "R6 pd 8x8");
      meas(2, 6'h35, 6,  "R6 pd 3x2");
      meas(2, 6'h3F, 1,  "R6 pd 1x1");
      meas(2, 6'h38, 8,  "R6 pd 8x1");
      meas(2, 6'h23, 20, "R6 pd 5x4");

      // R7: post code change mid-period takes effect only at wraps
      sync_tick(2);
      post_code = 6'h00;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 3) post_code = 6'h3F;
      end while (post_tick != 1'b1 && n < 2000);
      chk(n == 15, "R7 mixed period", n, 15);
      count_to_tick(2, n);
      chk(n == 1, "R7 settled period", n, 1);

      repeat (5) @(negedge clk);
      finish_up();
   end
endmodule